// File: doc/BRIEF.md
# Superfractional UART Bit-Period Timer

This block times the bit cells of an asynchronous serial character for a transmitter or a receiver. A 31-bit baud word sets the length of one bit cell in clock cycles. It holds a 24-bit integer prescaler, a 4-bit fraction and a 3-bit superfractional selector. The prescaler and fraction give a base length of sixteen times the prescaler plus one, plus the fraction.

The superfractional selector then adds one clock to chosen bit positions of the character. The chosen positions depend on the selector value and on the frame layout. This pulls the average rate between two neighbouring fractional settings.

A frame begins with a one-cycle start pulse. The block then steps through every position of the selected layout. It raises a sample strobe near the middle of each cell and a done strobe in the last cycle of each cell. After the last position it returns to idle. The shifting logic around it uses the strobes and the position index.

Top module: `sfrac_baud_timer`

## Requirements
- R1: The baud word `baudCfg` carries the prescaler P in bits [23:0], the fraction M in bits [27:24] and the selector U in bits [30:28]. When P is not 0, a bit cell lasts 16*(P+1)+M clock cycles, plus one cycle when the extra-clock bit of that position is set.
- R2: When P is 0, every bit cell lasts exactly 32 cycles, whatever the values of M, U and the frame type.
- R3: Frame type 2'd1 (and 2'd3, which behaves the same) has 10 positions: index 0 is start, 1..8 are D0..D7 and 9 is stop. The positions that get an extra clock are, by U: 0 none; 1 start and D7; 2 adds D3 to that; 3 adds D1 as well; 4 adds D5 as well; 5 is start, D0, D1, D3, D5, D7 and stop; 6 is U=5 plus D4; 7 is every position except D6.
- R4: Frame type 2'd2 has 13 positions: 0..8 as in R3, then 9 address, 10 parity, 11 first stop, 12 second stop. Positions 0..8 use the R3 pattern. For positions 9..12 (address, parity, stop0, stop1) the extra bits are: U=0 or 1 gives 0000; U=2 gives 0001; U=3 or 4 gives 0101; U=5 or 6 gives 1101; U=7 gives 1111.
- R5: Frame type 2'd0 has 3 positions: start, D0 and stop. The extra bits (start, D0, stop) are: U=0 gives 000; U=1 or 2 gives 100; U=3 or 4 gives 101; U=5, 6 or 7 gives 111.
- R6: When `asyncMode` is 0 at frame start, no position gets an extra clock in that frame.
- R7: `baudCfg`, `frameType` and `asyncMode` are captured in the cycle `frameStart` is high. Later changes have no effect on the running frame.
- R8: Cycles of a cell are numbered from 1. `sampleStrobe` is high in cycle floor(L/2)+1 of a cell of length L, and `bitDoneStrobe` is high in cycle L. The two strobes are never high together.
- R9: `frameStart` sets `bitIndex` to 0 and `busy` to 1 in the next cycle, even when a frame is already running. `bitIndex` advances by one after each done strobe and holds its value otherwise.
- R10: After reset, and after the done strobe of the last position, `busy` is 0 and `bitIndex` is 0. Both strobes stay low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | One-cycle pulse that begins a frame |
| frameType | input | 2 | Frame layout: 0 = 3 positions, 1 or 3 = 10 positions, 2 = 13 positions |
| asyncMode | input | 1 | Enables the superfractional extra clocks |
| baudCfg | input | 31 | Baud word {U, M, P} |
| sampleStrobe | output | 1 | Mid-cell sample pulse |
| bitDoneStrobe | output | 1 | Pulse in the last cycle of a cell |
| bitIndex | output | 4 | Current position in the frame |
| busy | output | 1 | High while a frame is being timed |

## Verification
Every cell of each frame is timed, over a table of frames that crosses the three layouts with several U values and small prescalers. This lets a single misplaced extra clock show up as a one-cycle error at a known index. Frames with P=0 and non-zero M and U must give flat 32-cycle cells. Frames with `asyncMode` low must give flat base-length cells. Together these separate the forced length and the mode gate from the pattern lookup. A change of the baud word right after frame start, a restart in the middle of a frame, and a long idle stretch check the capture, the index reset and the quiet idle strobes.

// File: rtl/sfrac_baud_pkg.sv
package sfrac_baud_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    FRM_SHORT  = 2'd0,
    FRM_NORMAL = 2'd1,
    FRM_FULL   = 2'd2,
    FRM_ALT    = 2'd3
  } frame_kind_e;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic run;
  } ctl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic sampleHit;
    logic bitEnd;
  } dp_flags_t;

  function automatic logic [IDX_W-1:0] lastPos(input frame_kind_e kind);
    case (kind)
      FRM_SHORT: lastPos = IDX_W'(2);
      FRM_FULL:  lastPos = IDX_W'(12);
      default:   lastPos = IDX_W'(9);
    endcase
  endfunction

  // 10-position core pattern, bit n = position n (0 = start, 9 = stop)
  function automatic logic [9:0] corePattern(input logic [2:0] u);
    case (u)
      3'd1:    corePattern = 10'h101;
      3'd2:    corePattern = 10'h111;
      3'd3:    corePattern = 10'h115;
      3'd4:    corePattern = 10'h155;
      3'd5:    corePattern = 10'h357;
      3'd6:    corePattern = 10'h377;
      3'd7:    corePattern = 10'h37F;
      default: corePattern = 10'h000;
    endcase
  endfunction

  // tail of 13-position layout, bit0 = address ... bit3 = second stop
  function automatic logic [3:0] tailPattern(input logic [2:0] u);
    case (u)
      3'd2:       tailPattern = 4'b1000;
      3'd3, 3'd4: tailPattern = 4'b1010;
      3'd5, 3'd6: tailPattern = 4'b1011;
      3'd7:       tailPattern = 4'b1111;
      default:    tailPattern = 4'b0000;
    endcase
  endfunction

  // 3-position layout, bit0 = start, bit1 = D0, bit2 = stop
  function automatic logic [2:0] shortPattern(input logic [2:0] u);
    case (u)
      3'd1, 3'd2:       shortPattern = 3'b001;
      3'd3, 3'd4:       shortPattern = 3'b101;
      3'd5, 3'd6, 3'd7: shortPattern = 3'b111;
      default:          shortPattern = 3'b000;
    endcase
  endfunction

  function automatic logic extraClock(input frame_kind_e kind,
                                      input logic [2:0] u,
                                      input logic [IDX_W-1:0] pos);
    logic [15:0] vec;
    vec = '0;
    case (kind)
      FRM_SHORT: vec[2:0]  = shortPattern(u);
      FRM_FULL:  vec[12:0] = {tailPattern(u), corePattern(u)[8:0]};
      default:   vec[9:0]  = corePattern(u);
    endcase
    extraClock = vec[pos];
  endfunction

endpackage

// File: rtl/sfrac_baud_ctrl.sv
module sfrac_baud_ctrl
  import sfrac_baud_pkg::*;
#(
  parameter int P_W = 24,
  parameter int M_W = 4,
  parameter int U_W = 3,
  localparam int CFG_W = P_W + M_W + U_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [1:0]       frameType,
  input  logic             asyncMode,
  input  logic [CFG_W-1:0] baudCfg,
  input  dp_flags_t        dpFlags,
  output ctl_strobe_t      ctl,
  output logic [P_W-1:0]   prescQ,
  output logic [M_W-1:0]   fracQ,
  output logic             extraBit,
  output logic [IDX_W-1:0] bitIndex,
  output logic             busy
);

  logic [U_W-1:0]   superQ;
  frame_kind_e      kindQ;
  logic             asyncQ;
  logic             busyQ;
  logic [IDX_W-1:0] idxQ;
  logic             atLast;
  logic [2:0]       uSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescQ <= '0;
      fracQ  <= '0;
      superQ <= '0;
      kindQ  <= FRM_SHORT;
      asyncQ <= 1'b0;
    end else if (frameStart) begin
      prescQ <= baudCfg[P_W-1:0];
      fracQ  <= baudCfg[P_W+M_W-1:P_W];
      superQ <= baudCfg[CFG_W-1:P_W+M_W];
      kindQ  <= frame_kind_e'(frameType);
      asyncQ <= asyncMode;
    end
  end

  assign atLast = (idxQ == lastPos(kindQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (frameStart) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
    end else if (busyQ && dpFlags.bitEnd) begin
      if (atLast) begin
        busyQ <= 1'b0;
        idxQ  <= '0;
      end else begin
        idxQ <= idxQ + IDX_W'(1);
      end
    end
  end

  generate
    if (U_W >= 3) begin : g_usel_trim
      assign uSel = superQ[2:0];
    end else begin : g_usel_pad
      assign uSel = 3'(superQ);
    end
  endgenerate

  assign extraBit = asyncQ && extraClock(kindQ, uSel, idxQ);
  assign ctl.load = frameStart;
  assign ctl.run  = busyQ;
  assign bitIndex = idxQ;
  assign busy     = busyQ;

endmodule

// File: rtl/sfrac_baud_datapath.sv
module sfrac_baud_datapath
  import sfrac_baud_pkg::*;
#(
  parameter int P_W       = 24,
  parameter int M_W       = 4,
  parameter int FIXED_LEN = 32,
  localparam int CNT_W    = P_W + M_W + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctl_strobe_t    ctl,
  input  logic [P_W-1:0] prescQ,
  input  logic [M_W-1:0] fracQ,
  input  logic           extraBit,
  output dp_flags_t      dpFlags
);

  logic [CNT_W-1:0] bitLen;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] midCnt;
  logic [CNT_W-1:0] cnt;
  logic             endHit;

  always_comb begin
    if (prescQ == '0) begin
      bitLen = CNT_W'(FIXED_LEN);
    end else begin
      bitLen = ((CNT_W'(prescQ) + CNT_W'(1)) << M_W)
             + CNT_W'(fracQ) + CNT_W'(extraBit);
    end
  end

  assign lastCnt = bitLen - CNT_W'(1);
  assign midCnt  = bitLen >> 1;
  assign endHit  = ctl.run && (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= '0;
    end else if (ctl.run) begin
      if (endHit) cnt <= '0;
      else        cnt <= cnt + CNT_W'(1);
    end
  end

  assign dpFlags.bitEnd    = endHit;
  assign dpFlags.sampleHit = ctl.run && (cnt == midCnt);

endmodule

// File: rtl/sfrac_baud_timer.sv
module sfrac_baud_timer
  import sfrac_baud_pkg::*;
#(
  parameter int P_W       = 24,
  parameter int M_W       = 4,
  parameter int U_W       = 3,
  parameter int FIXED_LEN = 32,
  localparam int CFG_W    = P_W + M_W + U_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [1:0]       frameType,
  input  logic             asyncMode,
  input  logic [CFG_W-1:0] baudCfg,
  output logic             sampleStrobe,
  output logic             bitDoneStrobe,
  output logic [IDX_W-1:0] bitIndex,
  output logic             busy
);

  ctl_strobe_t    ctl;
  dp_flags_t      dpFlags;
  logic [P_W-1:0] prescQ;
  logic [M_W-1:0] fracQ;
  logic           extraBit;

  sfrac_baud_ctrl #(.P_W(P_W), .M_W(M_W), .U_W(U_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .frameType  (frameType),
    .asyncMode  (asyncMode),
    .baudCfg    (baudCfg),
    .dpFlags    (dpFlags),
    .ctl        (ctl),
    .prescQ     (prescQ),
    .fracQ      (fracQ),
    .extraBit   (extraBit),
    .bitIndex   (bitIndex),
    .busy       (busy)
  );

  sfrac_baud_datapath #(.P_W(P_W), .M_W(M_W), .FIXED_LEN(FIXED_LEN)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .prescQ   (prescQ),
    .fracQ    (fracQ),
    .extraBit (extraBit),
    .dpFlags  (dpFlags)
  );

  assign sampleStrobe  = dpFlags.sampleHit;
  assign bitDoneStrobe = dpFlags.bitEnd;

endmodule

// File: rtl/sfrac_baud_timer_chk.sv
module sfrac_baud_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameStart,
  input logic       sampleStrobe,
  input logic       bitDoneStrobe,
  input logic [3:0] bitIndex,
  input logic       busy
);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sampleStrobe && !bitDoneStrobe));

  // R10
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !frameStart) |=> !busy);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStrobe && bitDoneStrobe));

  // R9
  start_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (busy && bitIndex == 4'd0));

  // R9
  index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitDoneStrobe && !frameStart) |=> $stable(bitIndex));

  // R9
  index_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitDoneStrobe && !frameStart) |=>
      (!busy || bitIndex == 4'($past(bitIndex) + 4'd1)));

endmodule

bind sfrac_baud_timer sfrac_baud_timer_chk i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .frameStart    (frameStart),
  .sampleStrobe  (sampleStrobe),
  .bitDoneStrobe (bitDoneStrobe),
  .bitIndex      (bitIndex),
  .busy          (busy)
);

// File: tb/test_sfrac_baud_timer.sv
module test_sfrac_baud_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [1:0]  frameType = 2'd1;
  logic        asyncMode = 1'b1;
  logic [30:0] baudCfg = '0;
  logic        sampleStrobe;
  logic        bitDoneStrobe;
  logic [3:0]  bitIndex;
  logic        busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sfrac_baud_timer i_sfrac_baud_timer (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameType(frameType),
    .asyncMode(asyncMode), .baudCfg(baudCfg), .sampleStrobe(sampleStrobe),
    .bitDoneStrobe(bitDoneStrobe), .bitIndex(bitIndex), .busy(busy)
  );

  // extra-clock patterns written in frame order, leftmost = start position
  localparam logic [9:0] EXP10 [8] = '{
    10'b0000000000, 10'b1000000010, 10'b1000100010, 10'b1010100010,
    10'b1010101010, 10'b1110101011, 10'b1110111011, 10'b1111111011};
  localparam logic [12:0] EXP13 [8] = '{
    13'b0000000000000, 13'b1000000010000, 13'b1000100010001, 13'b1010100010101,
    13'b1010101010101, 13'b1110101011101, 13'b1110111011101, 13'b1111111011111};
  localparam logic [2:0] EXP3 [8] = '{
    3'b000, 3'b100, 3'b100, 3'b101, 3'b101, 3'b111, 3'b111, 3'b111};

  // vector: {frameType[1:0], async, U[2:0], M[3:0], P[7:0]}
  localparam int NVEC = 16;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd1, 1'b1, 3'd0, 4'd0,  8'd1},
    {2'd1, 1'b1, 3'd1, 4'd3,  8'd1},
    {2'd1, 1'b1, 3'd5, 4'd7,  8'd1},
    {2'd1, 1'b1, 3'd7, 4'd15, 8'd2},
    {2'd2, 1'b1, 3'd2, 4'd1,  8'd1},
    {2'd2, 1'b1, 3'd6, 4'd0,  8'd1},
    {2'd2, 1'b1, 3'd7, 4'd9,  8'd1},
    {2'd2, 1'b1, 3'd3, 4'd0,  8'd1},
    {2'd0, 1'b1, 3'd3, 4'd2,  8'd1},
    {2'd0, 1'b1, 3'd7, 4'd0,  8'd1},
    {2'd0, 1'b1, 3'd1, 4'd0,  8'd1},
    {2'd1, 1'b0, 3'd7, 4'd4,  8'd1},
    {2'd0, 1'b1, 3'd5, 4'd15, 8'd0},
    {2'd2, 1'b1, 3'd7, 4'd5,  8'd0},
    {2'd3, 1'b1, 3'd4, 4'd0,  8'd1},
    {2'd1, 1'b1, 3'd0, 4'd0,  8'd26}};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int posCount(input logic [1:0] ft);
    if (ft == 2'd0) return 3;
    if (ft == 2'd2) return 13;
    return 10;
  endfunction

  function automatic int cellLen(input logic [1:0] ft, input logic a,
                                 input logic [2:0] u, input logic [3:0] m,
                                 input int p, input int pos);
    int extra;
    if (p == 0) return 32;
    if (ft == 2'd0)      extra = EXP3[u][2 - pos];
    else if (ft == 2'd2) extra = EXP13[u][12 - pos];
    else                 extra = EXP10[u][9 - pos];
    if (!a) extra = 0;
    return 16 * (p + 1) + int'(m) + extra;
  endfunction

  function automatic string tagFor(input logic [1:0] ft, input logic a, input int p);
    if (p == 0) return "R2";
    if (!a) return "R6";
    if (ft == 2'd0) return "R1 R5";
    if (ft == 2'd2) return "R1 R4";
    return "R1 R3";
  endfunction

  // runs a full frame; cfgLater is applied one cycle after the start pulse
  task automatic runFrame(input logic [1:0] ft, input logic a,
                          input logic [30:0] cfg, input logic [30:0] cfgLater,
                          input string tag);
    int n;
    logic [2:0] u;
    logic [3:0] m;
    int p;
    n = posCount(ft);
    u = cfg[30:28];
    m = cfg[27:24];
    p = int'(cfg[23:0]);
    @(negedge clk);
    frameType = ft; asyncMode = a; baudCfg = cfg; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0; baudCfg = cfgLater;
    frameType = ~ft; asyncMode = ~a;
    for (int pos = 0; pos < n; pos++) begin
      int c = 0;
      int sAt = 0;
      int idxBad = 0;
      bit done = 1'b0;
      int exp = cellLen(ft, a, u, m, p, pos);
      while (!done && c < 5000) begin
        c++;
        if (sampleStrobe) sAt = c;
        if (!busy || bitIndex != 4'(pos)) idxBad++;
        if (bitDoneStrobe) done = 1'b1;
        @(negedge clk);
      end
      check(c == exp, tag, $sformatf("cell length at position %0d", pos), c, exp);
      // R8 sample point
      check(sAt == exp / 2 + 1, "R8", $sformatf("sample cycle at position %0d", pos),
            sAt, exp / 2 + 1);
      // R9 index follows position
      check(idxBad == 0, "R9", $sformatf("index mismatches at position %0d", pos),
            idxBad, 0);
    end
    // R10 idle after last position
    check(!busy && bitIndex == 4'd0 && !sampleStrobe && !bitDoneStrobe, "R10",
          "idle after frame end", {busy, bitIndex, sampleStrobe, bitDoneStrobe}, 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && bitIndex == 4'd0 && !sampleStrobe && !bitDoneStrobe, "R10",
          "reset state", {busy, bitIndex, sampleStrobe, bitDoneStrobe}, 0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] ft;
      logic a;
      logic [30:0] cfg;
      ft  = VEC[v][17:16];
      a   = VEC[v][15];
      cfg = {VEC[v][14:12], VEC[v][11:8], 16'd0, VEC[v][7:0]};
      runFrame(ft, a, cfg, cfg, tagFor(ft, a, int'(VEC[v][7:0])));
    end

    // R7: baud word and mode changed right after start have no effect
    runFrame(2'd1, 1'b1, {3'd6, 4'd2, 24'd1}, {3'd0, 4'd9, 24'd3}, "R7");
    runFrame(2'd2, 1'b1, {3'd7, 4'd0, 24'd0}, {3'd1, 4'd1, 24'd1}, "R7");

    // R10: long idle, no strobes
    begin
      int noisy = 0;
      baudCfg = {3'd7, 4'd15, 24'd1};
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (busy || sampleStrobe || bitDoneStrobe) noisy++;
      end
      check(noisy == 0, "R10", "strobes during idle", noisy, 0);
    end

    // R9: restart in the middle of a frame
    @(negedge clk);
    frameType = 2'd1; asyncMode = 1'b1; baudCfg = {3'd0, 4'd0, 24'd1}; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    repeat (100) @(negedge clk);
    check(busy && bitIndex == 4'd3, "R9", "index before restart", bitIndex, 3);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    check(busy && bitIndex == 4'd0, "R9", "index after restart", bitIndex, 0);
    begin
      int c = 1;
      while (!bitDoneStrobe && c < 100) begin
        @(negedge clk);
        c++;
      end
      check(c == 32, "R9", "first cell length after restart", c, 32);
    end
    while (busy) @(negedge clk);
    check(bitIndex == 4'd0, "R10", "index back to 0 after restarted frame", bitIndex, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule